// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a single raw PWM waveform into a complementary pair of drive signals, one high-side and one low-side. Whenever the raw signal changes level, the output that is about to switch on waits for a programmable number of counter periods, while the output that switches off drops at once. The two switches of a half-bridge are therefore never on together, and a short gap separates their conduction intervals.

The delay is counted in periods of a counter clock, supplied as a one-cycle enable pulse `cnt_tick` in the system clock domain. An 8-bit configuration word, written through a simple write strobe, selects the delay length and turns the insertion on or off. With insertion off, the pair is the raw signal and its inverse. With insertion on and a zero length, both outputs are held low.

Top module: `pwm_deadband`

## Requirements
- R1: While `rst_n` is low, both `out_hi` and `out_lo` are low.
- R2: The configuration word resets to 0x00, so insertion is off after reset until software writes it.
- R3: With insertion off (bit 7 clear), `out_hi` equals `pwm_raw` and `out_lo` equals its inverse one clock after the raw level is sampled, whatever bits 6:0 hold.
- R4: A write with `cfg_we` high loads `cfg_wdata` on that clock edge. Bit 7 turns insertion on, and bits 6:0 give the delay length N in counter periods.
- R5: With insertion on and N>0, the output that turns on at a raw edge stays low until N `cnt_tick` pulses have been seen after the clock that sampled the edge. It rises on the clock that registers the Nth of those pulses.
- R6: Turn-off is immediate: `out_hi` is low one clock after `pwm_raw` is sampled low, and `out_lo` is low one clock after it is sampled high. The two outputs are never high together.
- R7: With insertion on and N equal to zero, both outputs are low.
- R8: A raw pulse that ends before its delay expires leaves the corresponding output low for the whole pulse.
- R9: A new value of N is taken at the next raw edge. A delay already running keeps the length it started with.
- R10: The delay advances only on clocks where `cnt_tick` is high. Clocks without it do not shorten the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: bit 7 insertion on, bits 6:0 delay length |
| cnt_tick | input | 1 | One-clock pulse per counter period |
| pwm_raw | input | 1 | Raw PWM input |
| out_hi | output | 1 | High-side output, follows the raw level |
| out_lo | output | 1 | Low-side output, follows the inverted raw level |

## Verification
The bench builds the block with its default count width of 7 bits. The full range of delay lengths is in reach, including the largest value of 127, with runs that stay short. Most stimulus uses a tick on every clock, so each raw edge can be lined up exactly with its delayed rise. One phase thins the tick to every third clock to show that only tick cycles count. Configuration writes land mid-pulse and during a running delay, which exercises the rule that a new length waits for the next edge.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
    typedef struct packed {
        logic hi;
        logic lo;
    } dbp_pair_t;

    localparam dbp_pair_t DBP_PAIR_IDLE = '{hi: 1'b0, lo: 1'b0};
endpackage

// File: rtl/dbp_cfg_reg.sv
module dbp_cfg_reg #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W:0]   wdata,
    output logic             ins_on,
    output logic [CNT_W-1:0] len
);
    localparam int CFG_W = CNT_W + 1;

    logic [CFG_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign ins_on = word_q[CNT_W];
    assign len    = word_q[CNT_W-1:0];

    // R4
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ({ins_on, len} == $past(wdata)));
endmodule

// File: rtl/dbp_edge.sv
module dbp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic changed
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign changed = (raw != prev_q);
endmodule

// File: rtl/dbp_timer.sv
module dbp_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_val,
    input  logic             clr,
    input  logic             tick,
    output logic             done
);
    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (clr)                          rem_d = '0;
        else if (arm)                     rem_d = arm_val;
        else if (tick && (rem_q != '0))   rem_d = rem_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign done = (rem_d == '0);

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !clr && !tick) |=> (rem_q == $past(rem_q)));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W:0]   cfg_wdata,
    input  logic             cnt_tick,
    input  logic             pwm_raw,
    output logic             out_hi,
    output logic             out_lo
);
    import dbp_pkg::*;

    logic             ins_on;
    logic [CNT_W-1:0] len;
    logic             raw_edge;
    logic             tmr_done;
    logic             len_zero;
    logic             delay_on;

    dbp_pair_t pair_d, pair_q;

    dbp_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .ins_on(ins_on), .len(len)
    );

    dbp_edge u_edge (
        .clk(clk), .rst_n(rst_n), .raw(pwm_raw), .changed(raw_edge)
    );

    assign len_zero = (len == '0);
    assign delay_on = ins_on && !len_zero;

    dbp_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .arm(delay_on && raw_edge), .arm_val(len),
        .clr(!delay_on), .tick(cnt_tick), .done(tmr_done)
    );

    always_comb begin
        pair_d = DBP_PAIR_IDLE;
        if (!ins_on) begin
            pair_d.hi = pwm_raw;
            pair_d.lo = !pwm_raw;
        end else if (!len_zero) begin
            pair_d.hi = pwm_raw && tmr_done;
            pair_d.lo = !pwm_raw && tmr_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= DBP_PAIR_IDLE;
        else        pair_q <= pair_d;
    end

    assign out_hi = pair_q.hi;
    assign out_lo = pair_q.lo;

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hi && out_lo));

    // R6
    hi_fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_raw |=> !out_hi);

    // R6
    lo_fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_raw |=> !out_lo);

    // R7
    zero_len_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_on && len_zero) |=> (!out_hi && !out_lo));

    // R3
    bypass_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_on |=> ((out_hi == $past(pwm_raw)) && (out_lo != $past(pwm_raw))));

    // R5
    wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_on && !tmr_done) |=> (!out_hi && !out_lo));
endmodule

// File: tb/sim_pwm_deadband.sv
`timescale 1ns/1ps
module sim_pwm_deadband;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cnt_tick = 1'b0;
    logic       pwm_raw = 1'b0;
    logic       out_hi, out_lo;

    always #10 clk = ~clk;

    pwm_deadband u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_tick(cnt_tick), .pwm_raw(pwm_raw), .out_hi(out_hi), .out_lo(out_lo)
    );

    typedef struct {
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;

    exp_t exq[$];
    int total = 0;
    int bad = 0;
    int gcyc = 0;

    // requirement-level model state
    logic [7:0] m_cfg = 8'h00;
    logic       m_prev = 1'b0;
    int         m_elapsed = 0;
    int         m_need = 0;

    task automatic check(input string tag, input logic ah, input logic al,
                         input logic eh, input logic el);
        total++;
        if (ah !== eh || al !== el) begin
            bad++;
            $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
                     tag, ah, al, eh, el, $time);
        end
    endtask

    task automatic step(input logic p, input int tick_per, input logic we,
                        input logic [7:0] wd, input string tag);
        exp_t e;
        logic t, on, chg;
        int n;
        @(negedge clk);
        t = ((gcyc % tick_per) == 0);
        gcyc++;
        pwm_raw = p; cnt_tick = t; cfg_we = we; cfg_wdata = wd;
        on  = m_cfg[7];
        n   = int'(m_cfg[6:0]);
        chg = (p != m_prev);
        if (chg) m_elapsed = 0;
        else if (t && m_elapsed < 1000) m_elapsed++;
        if (!on || n == 0) m_need = 0;
        else if (chg) m_need = n;
        e.tag = tag;
        if (!on) begin
            e.hi = p; e.lo = !p;
        end else if (n == 0) begin
            e.hi = 1'b0; e.lo = 1'b0;
        end else begin
            e.hi = p && (m_elapsed >= m_need);
            e.lo = !p && (m_elapsed >= m_need);
        end
        exq.push_back(e);
        m_prev = p;
        if (we) m_cfg = wd;
    endtask

    task automatic hold(input logic p, input int cycles, input int tick_per,
                        input string tag);
        for (int i = 0; i < cycles; i++) step(p, tick_per, 1'b0, 8'h00, tag);
    endtask

    task automatic write_cfg(input logic p, input logic [7:0] wd, input string tag);
        step(p, 1, 1'b1, wd, tag);
    endtask

    // monitor: compare outputs after each registering edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exq.size() > 0) begin
                exp_t e;
                e = exq.pop_front();
                check(e.tag, out_hi, out_lo, e.hi, e.lo);
                // R6 never both active
                total++;
                if (out_hi && out_lo) begin
                    bad++;
                    $display("FAIL R6: actual hi=%b lo=%b expected not both high", out_hi, out_lo);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs low during reset
        check("R1", out_hi, out_lo, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 insertion off after reset: plain complementary pair
        hold(1'b0, 3, 1, "R2");
        hold(1'b1, 3, 1, "R2");
        hold(1'b0, 1, 1, "R2");
        hold(1'b1, 1, 1, "R2");
        hold(1'b0, 2, 1, "R2");

        // R4 enable with N=3
        write_cfg(1'b0, 8'h83, "R4");
        hold(1'b0, 5, 1, "R4");
        // R5 / R6 long pulses
        hold(1'b1, 8, 1, "R5");
        hold(1'b0, 8, 1, "R6");
        hold(1'b1, 6, 1, "R5");
        hold(1'b0, 6, 1, "R6");

        // R8 pulses shorter than the delay
        hold(1'b1, 2, 1, "R8");
        hold(1'b0, 8, 1, "R8");
        hold(1'b1, 1, 1, "R8");
        hold(1'b0, 2, 1, "R8");
        hold(1'b1, 8, 1, "R8");

        // R10 sparse ticks
        hold(1'b0, 20, 3, "R10");
        hold(1'b1, 20, 3, "R10");
        hold(1'b0, 15, 4, "R10");

        // R7 enabled with zero length
        write_cfg(1'b0, 8'h80, "R7");
        hold(1'b0, 4, 1, "R7");
        hold(1'b1, 4, 1, "R7");
        hold(1'b0, 4, 1, "R7");

        // R9 length change mid-delay waits for next edge
        write_cfg(1'b0, 8'h84, "R9");
        hold(1'b0, 6, 1, "R9");
        hold(1'b1, 2, 1, "R9");
        write_cfg(1'b1, 8'h86, "R9");
        hold(1'b1, 6, 1, "R9");
        hold(1'b0, 10, 1, "R9");
        hold(1'b1, 10, 1, "R9");

        // R3 off with nonzero length bits
        write_cfg(1'b1, 8'h05, "R3");
        hold(1'b0, 2, 1, "R3");
        hold(1'b1, 2, 1, "R3");
        hold(1'b0, 1, 1, "R3");

        // R5 largest length
        write_cfg(1'b0, 8'hFF, "R5");
        hold(1'b0, 135, 1, "R5");
        hold(1'b1, 135, 1, "R5");
        hold(1'b0, 20, 1, "R5");

        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule